// File: doc/BRIEF.md
# Log-Domain Base and Detail Enhancement Merger

This block belongs to a low-light video pipeline. It sits after an edge-preserving smoothing filter and receives, for each pixel, three values: the original sample, the smoothed (base) sample and the filter's local kernel weight. The block splits the pixel into a base part and a detail part using natural logarithms. It compresses or stretches the base part in the log domain so that the previous frame's spread of log-base values is mapped onto a programmable target contrast. It amplifies the detail part with a gain that adapts per pixel to the kernel weight. It then converts both parts back out of the log domain and adds them into one 14-bit output pixel.

Logarithm and exponential are evaluated by small computed tables with linear interpolation. All intermediate values are fixed point with ten fractional bits. The scale and the offset for a frame come from the extremes of the log base that were seen during the frame before it. Those extremes are captured on the flagged last pixel, and the coefficients are ready two cycles later.

Top module: `enh_merge`

## Requirements
- R1: Each pixel accepted with `in_valid` high appears on `out_pix` with `out_valid` high exactly two clock cycles later. In every cycle without a pixel `out_valid` is low and `out_pix` keeps its value.
- R2: After synchronous reset `out_valid` and `out_pix` are 0. Until the first frame ends, the base scale is 1 and the base offset is 0, so the enhanced base equals `in_base` + 1.
- R3: The output is E = exp(U) + 1.5 · exp(ln(I+1) − ln(B+1)) · g, with U = β·ln(B+1) + γ, I = `in_orig` and B = `in_base`, rounded to an integer within 4 codes plus 3 percent.
- R4: `in_weight` W is unsigned fixed point with 10 fractional bits (1024 means 1.0). The detail gain is g = 1 + 1.5·(1 − 1/(W+1)), so W = 0 gives g = 1 and large W brings g towards 2.5.
- R5: On a pixel with `in_last` high, the maximum and minimum of ln(B+1) over that frame's valid pixels, this pixel included, are captured. Then β = ln(T)/(max − min) and γ = (1 − β)·max are formed, with T = `contrast_t` (an integer of at least 1, read at that point). They apply to a frame whose first pixel comes at least two idle cycles after the last one.
- R6: If the captured maximum equals the minimum, β = 1 and γ = 0 for the next frame.
- R7: An output value above 16383 is clamped to 16383.
- R8: Cycles with `in_valid` low have no effect on the frame extremes, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_last | input | 1 | Marks the last pixel of a frame |
| in_orig | input | 14 | Original pixel I |
| in_base | input | 14 | Base-layer pixel B |
| in_weight | input | 16 | Kernel weight, 10 fractional bits |
| contrast_t | input | 16 | Target contrast T, integer at least 1 |
| out_valid | output | 1 | Enhanced pixel present |
| out_pix | output | 14 | Enhanced pixel |

## Verification
The hardest case to reach from the ports is a frame whose coefficients depend on statistics that the previous frame should have left alone. Two cases need a full frame to pass before they show: garbage data on idle cycles, which must not move the extremes, and a flat frame, which must collapse β to one. The stimulus therefore chains frames. A wide frame is followed by one whose valid pixels all share a single base value, with extreme values driven during idle gaps. The frame after that has outputs that match only if both the ignore rule and the flat-span rule held. A later frame changes T, and the frame after it shows whether the new value was taken at the end of the frame.

// File: rtl/enh_pkg.sv
package enh_pkg;
  localparam int QF      = 10;
  localparam int Q_ONE   = 1 << QF;
  localparam int LN2_Q   = 710;
  localparam int LOG2E_Q = 1477;
  localparam int LN_ONE  = 10 * LN2_Q;
  localparam int ETA_Q   = 1536;
  localparam int GMIN_Q  = 1024;
  localparam int GSPAN_Q = 1536;
  localparam int LW      = 20;
  localparam int CW      = 40;
  localparam int U_LIM   = 16384;
  localparam int SEGS    = 16;
endpackage

// File: rtl/enh_ln.sv
module enh_ln
  import enh_pkg::*;
#(
  parameter int XW = 18,
  parameter int OW = LW
) (
  input  logic [XW-1:0]        x,
  output logic signed [OW-1:0] y
);
  logic [15:0] tab [0:SEGS];

  for (genvar i = 0; i <= SEGS; i++) begin : g_tab
    localparam int V = $rtoi($ln(1.0 + real'(i) / real'(SEGS)) * 1024.0 + 0.5);
    assign tab[i] = 16'(V);
  end

  always_comb begin
    int     e;
    longint t;
    logic [4:0] idx;
    int     frc, lo, hi, acc;
    e = 0;
    for (int k = 0; k < XW; k++) if (x[k]) e = k;
    t   = (longint'(x) << 14) >> e;
    idx = 5'((t >> 10) & 15);
    frc = int'(t & 1023);
    lo  = int'(tab[idx]);
    hi  = int'(tab[idx + 5'd1]);
    acc = e * LN2_Q + lo + ((hi - lo) * frc) / 1024;
    y   = OW'(acc);
  end
endmodule

// File: rtl/enh_exp.sv
module enh_exp
  import enh_pkg::*;
#(
  parameter int IW = LW,
  parameter int OW = 28
) (
  input  logic signed [IW-1:0] x,
  output logic [OW-1:0]        y
);
  logic [11:0] tab [0:SEGS];

  for (genvar i = 0; i <= SEGS; i++) begin : g_tab
    localparam int V = $rtoi($pow(2.0, real'(i) / real'(SEGS)) * 1024.0 + 0.5);
    assign tab[i] = 12'(V);
  end

  always_comb begin
    longint p, k, fr, r;
    logic [4:0] idx;
    int     f6, lo, hi, m;
    p   = (longint'(x) * LOG2E_Q) >>> 10;
    k   = p >>> 10;
    fr  = p & 1023;
    idx = 5'(fr >> 6);
    f6  = int'(fr & 63);
    lo  = int'(tab[idx]);
    hi  = int'(tab[idx + 5'd1]);
    m   = lo + ((hi - lo) * f6) / 64;
    if (k > longint'(OW - 11))  r = (longint'(1) << OW) - 1;
    else if (k >= 0)            r = longint'(m) << k;
    else if (k < -12)           r = 0;
    else                        r = longint'(m) >> (-k);
    y = OW'(r);
  end
endmodule

// File: rtl/enh_fstat.sv
module enh_fstat #(
  parameter int VW = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic                 last,
  input  logic signed [VW-1:0] val,
  output logic signed [VW-1:0] fmax,
  output logic signed [VW-1:0] fmin,
  output logic                 done
);
  logic signed [VW-1:0] rmax, rmin, cmax, cmin;
  logic                 first;

  always_comb begin
    cmax = (first || val > rmax) ? val : rmax;
    cmin = (first || val < rmin) ? val : rmin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first <= 1'b1;
      rmax  <= '0;
      rmin  <= '0;
      fmax  <= '0;
      fmin  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (upd) begin
        if (last) begin
          fmax  <= cmax;
          fmin  <= cmin;
          done  <= 1'b1;
          first <= 1'b1;
        end else begin
          rmax  <= cmax;
          rmin  <= cmin;
          first <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/enh_merge.sv
module enh_merge
  import enh_pkg::*;
#(
  parameter int PIX_W = 14,
  parameter int WGT_W = 16,
  parameter int CT_W  = 16,
  parameter int LNX_W = 18,
  parameter int EXP_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [PIX_W-1:0] in_orig,
  input  logic [PIX_W-1:0] in_base,
  input  logic [WGT_W-1:0] in_weight,
  input  logic [CT_W-1:0]  contrast_t,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  localparam longint PIX_MAX = (longint'(1) << PIX_W) - 1;

  logic signed [LW-1:0] ln_i, ln_b, ln_w, ln_t;
  logic signed [LW-1:0] s1_li, s1_lb, s1_lw;
  logic                 s1_v, s1_last;
  logic signed [LW-1:0] st_max, st_min;
  logic                 st_done;
  logic signed [CW-1:0] beta_q, gamma_q, beta_n, gamma_n;
  logic signed [LW-1:0] u_c, d_c, nlw_c;
  logic [EXP_W-1:0]     e_u, e_d, e_f;
  logic [15:0]          gain_c;
  logic [PIX_W-1:0]     pix_c;

  enh_ln #(.XW(LNX_W)) u_ln_i (.x(LNX_W'(in_orig) + LNX_W'(1)),         .y(ln_i));
  enh_ln #(.XW(LNX_W)) u_ln_b (.x(LNX_W'(in_base) + LNX_W'(1)),         .y(ln_b));
  enh_ln #(.XW(LNX_W)) u_ln_w (.x(LNX_W'(in_weight) + LNX_W'(Q_ONE)),   .y(ln_w));
  enh_ln #(.XW(LNX_W)) u_ln_t (.x(LNX_W'(contrast_t)),                  .y(ln_t));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      s1_li   <= '0;
      s1_lb   <= '0;
      s1_lw   <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_last <= in_last;
      if (in_valid) begin
        s1_li <= ln_i;
        s1_lb <= ln_b;
        s1_lw <= ln_w - LW'(LN_ONE);
      end
    end
  end

  enh_fstat #(.VW(LW)) u_stat (
    .clk(clk), .rst(rst), .upd(s1_v), .last(s1_last), .val(s1_lb),
    .fmax(st_max), .fmin(st_min), .done(st_done)
  );

  always_comb begin
    longint span, b;
    span = longint'(st_max) - longint'(st_min);
    b    = (span > 0) ? (longint'(ln_t) * Q_ONE) / span : longint'(Q_ONE);
    beta_n  = CW'(b);
    gamma_n = CW'(((longint'(Q_ONE) - b) * longint'(st_max)) >>> QF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beta_q  <= CW'(Q_ONE);
      gamma_q <= '0;
    end else if (st_done) begin
      beta_q  <= beta_n;
      gamma_q <= gamma_n;
    end
  end

  always_comb begin
    longint u;
    u = ((longint'(beta_q) * longint'(s1_lb)) >>> QF) + longint'(gamma_q);
    if (u > U_LIM)  u = U_LIM;
    if (u < -U_LIM) u = -U_LIM;
    u_c   = LW'(u);
    d_c   = s1_li - s1_lb;
    nlw_c = -s1_lw;
  end

  enh_exp #(.OW(EXP_W)) u_exp_u (.x(u_c),   .y(e_u));
  enh_exp #(.OW(EXP_W)) u_exp_d (.x(d_c),   .y(e_d));
  enh_exp #(.OW(EXP_W)) u_exp_f (.x(nlw_c), .y(e_f));

  always_comb begin
    longint om, g, det, sum, px;
    om = longint'(Q_ONE) - longint'(e_f);
    if (om < 0) om = 0;
    g   = GMIN_Q + ((GSPAN_Q * om) >>> QF);
    det = (longint'(e_d) * g) >>> QF;
    sum = longint'(e_u) + ((ETA_Q * det) >>> QF);
    px  = (sum + (Q_ONE / 2)) >>> QF;
    if (px > PIX_MAX) px = PIX_MAX;
    gain_c = 16'(g);
    pix_c  = PIX_W'(px);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) out_pix <= pix_c;
    end
  end
endmodule

// File: rtl/enh_merge_chk.sv
module enh_merge_chk #(
  parameter int PIX_W = 14,
  parameter int VW    = 20,
  parameter int CW    = 40
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [PIX_W-1:0]     out_pix,
  input logic [15:0]          gain,
  input logic signed [VW-1:0] lw,
  input logic                 lat,
  input logic signed [VW-1:0] fmax,
  input logic signed [VW-1:0] fmin,
  input logic signed [CW-1:0] beta
);
  AST_LAT_ON: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid); // R1
  AST_LAT_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_pix)); // R1
  AST_UNIT_GAIN: assert property (@(posedge clk) disable iff (rst)
    (lw == '0) |-> (gain == 16'd1024)); // R4
  AST_FLAT_BETA: assert property (@(posedge clk) disable iff (rst)
    (lat && fmax == fmin) |=> (beta == CW'(1024))); // R6
endmodule

bind enh_merge enh_merge_chk #(.PIX_W(PIX_W), .VW(enh_pkg::LW), .CW(enh_pkg::CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .out_pix(out_pix),
  .gain(gain_c), .lw(s1_lw), .lat(st_done), .fmax(st_max), .fmin(st_min), .beta(beta_q)
);

// File: tb/sim_enh_merge.sv
`timescale 1ns/1ps
module sim_enh_merge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [13:0] in_orig = '0, in_base = '0;
  logic [15:0] in_weight = '0, contrast_t = 16'd1;
  logic        out_valid;
  logic [13:0] out_pix;

  always #2 clk = ~clk;

  enh_merge u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_orig(in_orig), .in_base(in_base), .in_weight(in_weight),
    .contrast_t(contrast_t), .out_valid(out_valid), .out_pix(out_pix)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R3";
  int unsigned seed = 32'h1234_5678;

  real m_beta = 1.0, m_gamma = 0.0, r_max = 0.0, r_min = 0.0;
  bit  r_first = 1;

  bit    qv[$];
  real   qe[$];
  string qr[$];

  function automatic int unsigned rnd(int unsigned lim);
    seed = seed * 32'd1103515245 + 32'd12345;
    return (seed >> 8) % lim;
  endfunction

  function automatic real model_px(int i_, int b_, int w_, bit last_);
    real lb, li, eb, f, g, o, span;
    lb = $ln(b_ + 1.0);
    li = $ln(i_ + 1.0);
    eb = $exp(m_beta * lb + m_gamma);
    f  = 1.0 / (w_ / 1024.0 + 1.0);
    g  = 1.0 + (1.0 - f) * 1.5;
    o  = eb + 1.5 * $exp(li - lb) * g;
    if (o > 16383.0) o = 16383.0;
    if (r_first || lb > r_max) r_max = lb;
    if (r_first || lb < r_min) r_min = lb;
    r_first = 0;
    if (last_) begin
      span = r_max - r_min;
      if (span <= 0.0) m_beta = 1.0;
      else m_beta = $ln(real'(contrast_t)) / span;
      m_gamma = (1.0 - m_beta) * r_max;
      r_first = 1;
    end
    return o;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      qv.delete(); qe.delete(); qr.delete();
    end else begin
      real e;
      e = 0.0;
      if (in_valid) e = model_px(int'(in_orig), int'(in_base), int'(in_weight), in_last);
      qv.push_back(in_valid);
      qe.push_back(e);
      qr.push_back(cur_req);
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished && qv.size() >= 2) begin
      bit v; real ex, tol, df; string rq;
      v = qv.pop_front(); ex = qe.pop_front(); rq = qr.pop_front();
      n_cmp++;
      if (out_valid !== v) begin
        n_bad++;
        $display("FAIL %s R1 out_valid actual %0b expected %0b", rq, out_valid, v);
      end else if (v) begin
        tol = 4.0 + 0.03 * ex;
        df  = real'(out_pix) - ex;
        if (df < 0.0) df = -df;
        if (df > tol) begin
          n_bad++;
          $display("FAIL %s out_pix actual %0d expected %0.1f", rq, out_pix, ex);
        end
      end
    end
  end

  task automatic send(int i_, int b_, int w_, bit last_);
    in_valid  <= 1'b1;
    in_last   <= last_;
    in_orig   <= 14'(i_);
    in_base   <= 14'(b_);
    in_weight <= 16'(w_);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      in_valid  <= 1'b0;
      in_last   <= 1'b1;
      in_orig   <= 14'd16383;
      in_base   <= 14'd0;
      in_weight <= 16'hFFFF;
      @(negedge clk);
    end
  endtask

  task automatic rand_frame(int n, int bmin, int bspan);
    for (int k = 0; k < n; k++) begin
      int b, i;
      b = bmin + int'(rnd(bspan));
      i = b + int'(rnd(600)) - 300;
      if (i < 0) i = 0;
      if (i > 16383) i = 16383;
      send(i, b, int'(rnd(65536)), k == n - 1);
      if (k % 7 == 3) idle(1);
    end
    idle(3);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_pix !== 14'd0) begin
      n_bad++;
      $display("FAIL R2 reset state actual %0b/%0d expected 0/0", out_valid, out_pix);
    end
    rst <= 1'b0;
    contrast_t <= 16'd40;
    idle(2);
    // R2 R3 R4: first frame, unit scale, mix of weights
    cur_req = "R2";
    send(100, 100, 0, 0);
    send(5000, 2000, 0, 0);
    cur_req = "R4";
    send(50, 3000, 1024, 0);
    send(16383, 20, 65535, 0);
    idle(2);
    cur_req = "R3";
    send(0, 0, 0, 0);
    send(8000, 8000, 512, 0);
    send(300, 9000, 40000, 0);
    cur_req = "R7";
    send(16383, 16383, 0, 0);
    send(16383, 16383, 65535, 1);
    idle(3);
    // R5: frame scaled by previous extremes
    cur_req = "R5";
    rand_frame(24, 200, 12000);
    // R8: flat frame with extreme garbage on idle cycles
    cur_req = "R8";
    for (int k = 0; k < 10; k++) begin
      send(2800 + 40 * k, 3000, int'(rnd(65536)), k == 9);
      idle(2);
    end
    idle(1);
    // R6: frame after the flat one runs at unit scale
    cur_req = "R6";
    rand_frame(20, 50, 15000);
    contrast_t <= 16'd200;
    @(negedge clk);
    // R5: coefficients taken with the new target contrast
    cur_req = "R5";
    rand_frame(20, 500, 9000);
    cur_req = "R3";
    rand_frame(16, 1000, 6000);
    idle(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule